// File: doc/BRIEF.md
# Three-Weight Pseudo-Random Test Pattern Generator

This block drives the inputs of a combinational circuit under test with weighted pseudo-random patterns in which every input bit has one of only three weights: one half, taken straight from a pseudo-random source, or a constant 0 or 1. A 16-bit maximal-length LFSR produces one fresh bit per clock. That bit enters a shift register with exactly one cell per circuit input, and no cell is shared between inputs.

A binary phase counter selects the active weight assignment. Each assignment is a pair of per-input vectors set at build time: a force-enable vector and a force-value vector. The first assignment forces nothing, so the run opens with purely random patterns. Later assignments pin more inputs to constants. Exactly PAT_CNT valid patterns are produced in each phase. After the last phase the generator stops and raises done until software or a sequencer pulses start again.

An input that no assignment ever forces is wired directly to its shift-register cell. Every other input goes through a three-gate cell that is driven by the decoded phase: a set gate, a clear gate and a 2-input combine gate.

Top module: `tri_weight_pgen`

## Requirements
- R1: While rst_ni is low, and afterwards until the first start, valid_o and done_o are 0 and phase_o is 0.
- R2: A start pulse loads the LFSR with SEED and clears the shift register. From then on, in every clock of the fill and run periods, the LFSR shifts left and the feedback bit enters LFSR bit 0 and shift-register bit 0, while the shift register moves toward higher indices. The feedback bit is the XOR of LFSR bits 15, 13, 12 and 10, which gives the polynomial x^16+x^14+x^13+x^11+1.
- R3: valid_o first rises exactly N_IN clock edges after the edge that samples start_i.
- R4: An input bit i that is not forced in the active phase equals shift-register bit i. Phase 0 forces no input.
- R5: An input bit i with force-enable bit [phase][i] set equals force-value bit [phase][i]. In the bench setup, bit 3 is 1 in phase 1 and 0 in phase 2.
- R6: phase_o takes the binary codes 0, 1, … N_PHASE-1 in order, advancing only by one. Each phase holds for exactly PAT_CNT cycles with valid_o high.
- R7: After the PAT_CNT-th valid pattern of the last phase, done_o is 1 and valid_o is 0. The two are never high together, and pat_o stays stable while done_o is high.
- R8: A start pulse at any time, including mid-run or while done_o is high, restarts the run: on the next cycle valid_o and done_o are 0 and phase_o is 0.
- R9: done_o stays high until the next start pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle pulse that (re)starts a run |
| valid_o | output | 1 | pat_o holds a counted pattern this cycle |
| pat_o | output | N_IN | Pattern bus to the circuit under test |
| phase_o | output | PH_W | Binary index of the active weight assignment |
| done_o | output | 1 | All phases complete; held until next start |

## Verification
The case hardest to reach from the ports is a restart that lands on the final pattern of a phase, or of the last phase, where the counter rollover and the restart compete on the same edge. The stimulus gets there in two ways. It issues start pulses after random waits that span the whole run length, so some of them fall on phase boundaries and in the done state. It also adds directed full runs that measure the fill latency and the number of valid patterns in each phase. A bench model of the LFSR and the shift register predicts every pattern bit, and the comparison is made in each valid cycle.

// File: rtl/wpg_pkg.sv
package wpg_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_FILL = 2'd1,
    ST_RUN  = 2'd2,
    ST_DONE = 2'd3
  } wpg_state_e;

  localparam int unsigned LFSR_W_DEF = 16;
  // x^16 + x^14 + x^13 + x^11 + 1, taps on state bits 15,13,12,10
  localparam logic [LFSR_W_DEF-1:0] LFSR_TAPS_DEF = 16'hB400;
endpackage

// File: rtl/wpg_lfsr.sv
module wpg_lfsr #(
  parameter int unsigned W    = 16,
  parameter logic [W-1:0] TAPS = 16'hB400,
  parameter logic [W-1:0] SEED = 16'hACE1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic step_i,
  output logic bit_o
);
  logic [W-1:0] q;
  logic         fb;

  assign fb    = ^(q & TAPS);
  assign bit_o = fb;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      q <= SEED;
    else if (load_i)  q <= SEED;
    else if (step_i)  q <= {q[W-2:0], fb};
  end
endmodule

// File: rtl/wpg_seq.sv
module wpg_seq
  import wpg_pkg::*;
#(
  parameter int unsigned N_IN    = 8,
  parameter int unsigned N_PHASE = 3,
  parameter int unsigned PAT_CNT = 1024,
  localparam int unsigned PH_W   = (N_PHASE > 1) ? $clog2(N_PHASE) : 1,
  localparam int unsigned CNT_W  = (PAT_CNT > 1) ? $clog2(PAT_CNT) : 1,
  localparam int unsigned FILL_W = $clog2(N_IN + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  output logic            shift_o,
  output logic            valid_o,
  output logic            done_o,
  output logic [PH_W-1:0] phase_o
);
  localparam logic [FILL_W-1:0] FILL_LAST = FILL_W'(N_IN - 1);
  localparam logic [CNT_W-1:0]  CNT_LAST  = CNT_W'(PAT_CNT - 1);
  localparam logic [PH_W-1:0]   PH_LAST   = PH_W'(N_PHASE - 1);

  wpg_state_e        state_q;
  logic [FILL_W-1:0] fill_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [PH_W-1:0]   phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      fill_q  <= '0;
      cnt_q   <= '0;
      phase_q <= '0;
    end else if (start_i) begin
      state_q <= ST_FILL;
      fill_q  <= '0;
      cnt_q   <= '0;
      phase_q <= '0;
    end else begin
      unique case (state_q)
        ST_FILL: begin
          if (fill_q == FILL_LAST) state_q <= ST_RUN;
          else                     fill_q  <= fill_q + 1'b1;
        end
        ST_RUN: begin
          if (cnt_q == CNT_LAST) begin
            cnt_q <= '0;
            if (phase_q == PH_LAST) state_q <= ST_DONE;
            else                    phase_q <= phase_q + 1'b1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  assign shift_o = (state_q == ST_FILL) || (state_q == ST_RUN);
  assign valid_o = (state_q == ST_RUN);
  assign done_o  = (state_q == ST_DONE);
  assign phase_o = phase_q;
endmodule

// File: rtl/wpg_phase_dec.sv
module wpg_phase_dec #(
  parameter int unsigned N_PHASE = 3,
  localparam int unsigned PH_W   = (N_PHASE > 1) ? $clog2(N_PHASE) : 1
) (
  input  logic [PH_W-1:0]    phase_i,
  output logic [N_PHASE-1:0] sel_o
);
  for (genvar p = 0; p < N_PHASE; p++) begin : g_dec
    assign sel_o[p] = (phase_i == PH_W'(p));
  end
endmodule

// File: rtl/wpg_cell.sv
// Three-gate weight cell: set gate, clear gate, 2-input combine.
module wpg_cell #(
  parameter int unsigned N_PHASE = 3,
  parameter logic [N_PHASE-1:0] SET_M = '0,
  parameter logic [N_PHASE-1:0] CLR_M = '0
) (
  input  logic [N_PHASE-1:0] sel_i,
  input  logic               rnd_i,
  output logic               bit_o
);
  logic set_w, clr_w;
  assign set_w = |(sel_i & SET_M);
  assign clr_w = |(sel_i & CLR_M);
  assign bit_o = (rnd_i & ~clr_w) | set_w;
endmodule

// File: rtl/tri_weight_pgen.sv
module tri_weight_pgen
  import wpg_pkg::*;
#(
  parameter int unsigned N_IN    = 8,
  parameter int unsigned N_PHASE = 3,
  parameter int unsigned PAT_CNT = 1024,
  parameter logic [LFSR_W_DEF-1:0] SEED = 16'hACE1,
  parameter logic [N_PHASE-1:0][N_IN-1:0] FORCE_EN  = {8'h3F, 8'h0F, 8'h00},
  parameter logic [N_PHASE-1:0][N_IN-1:0] FORCE_VAL = {8'h26, 8'h09, 8'h00},
  localparam int unsigned PH_W = (N_PHASE > 1) ? $clog2(N_PHASE) : 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  output logic            valid_o,
  output logic [N_IN-1:0] pat_o,
  output logic [PH_W-1:0] phase_o,
  output logic            done_o
);
  function automatic logic [N_PHASE-1:0] set_col(int idx);
    logic [N_PHASE-1:0] m;
    for (int p = 0; p < N_PHASE; p++) m[p] = FORCE_EN[p][idx] & FORCE_VAL[p][idx];
    return m;
  endfunction

  function automatic logic [N_PHASE-1:0] clr_col(int idx);
    logic [N_PHASE-1:0] m;
    for (int p = 0; p < N_PHASE; p++) m[p] = FORCE_EN[p][idx] & ~FORCE_VAL[p][idx];
    return m;
  endfunction

  logic               shift_w, rnd_w;
  logic [N_PHASE-1:0] sel_w;
  logic [N_IN-1:0]    sr_q;

  wpg_lfsr #(
    .W   (LFSR_W_DEF),
    .TAPS(LFSR_TAPS_DEF),
    .SEED(SEED)
  ) i_lfsr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(start_i),
    .step_i(shift_w),
    .bit_o (rnd_w)
  );

  wpg_seq #(
    .N_IN   (N_IN),
    .N_PHASE(N_PHASE),
    .PAT_CNT(PAT_CNT)
  ) i_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_i),
    .shift_o(shift_w),
    .valid_o(valid_o),
    .done_o (done_o),
    .phase_o(phase_o)
  );

  wpg_phase_dec #(.N_PHASE(N_PHASE)) i_dec (
    .phase_i(phase_o),
    .sel_o  (sel_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       sr_q <= '0;
    else if (start_i)  sr_q <= '0;
    else if (shift_w)  sr_q <= {sr_q[N_IN-2:0], rnd_w};
  end

  for (genvar i = 0; i < N_IN; i++) begin : g_bit
    localparam logic [N_PHASE-1:0] SET_M = set_col(i);
    localparam logic [N_PHASE-1:0] CLR_M = clr_col(i);
    if ((SET_M | CLR_M) == '0) begin : g_wire
      assign pat_o[i] = sr_q[i];
    end else begin : g_gate
      wpg_cell #(
        .N_PHASE(N_PHASE),
        .SET_M  (SET_M),
        .CLR_M  (CLR_M)
      ) i_cell (
        .sel_i(sel_w),
        .rnd_i(sr_q[i]),
        .bit_o(pat_o[i])
      );
    end
  end
endmodule

// File: rtl/wpg_chk.sv
module wpg_chk #(
  parameter int unsigned N_IN    = 8,
  parameter int unsigned N_PHASE = 3,
  localparam int unsigned PH_W   = (N_PHASE > 1) ? $clog2(N_PHASE) : 1
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            start_i,
  input logic            valid_o,
  input logic            done_o,
  input logic [PH_W-1:0] phase_o,
  input logic [N_IN-1:0] pat_o,
  input logic [N_IN-1:0] sr_i
);
  // R7
  valid_done_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_o && done_o));

  // R6
  phase_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_o <= PH_W'(N_PHASE - 1));

  // R6
  phase_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> (phase_o == $past(phase_o)) || (phase_o == PH_W'($past(phase_o) + 1'b1)));

  // R8
  restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (!valid_o && !done_o && phase_o == '0));

  // R9
  done_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> done_o);

  // R4
  rnd_phase0_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && phase_o == '0) |-> (pat_o == sr_i));

  // R7
  pat_stable_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> $stable(pat_o));
endmodule

bind tri_weight_pgen wpg_chk #(.N_IN(N_IN), .N_PHASE(N_PHASE)) i_wpg_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .start_i(start_i),
  .valid_o(valid_o),
  .done_o (done_o),
  .phase_o(phase_o),
  .pat_o  (pat_o),
  .sr_i   (sr_q)
);

// File: tb/test_tri_weight_pgen.sv
`timescale 1ns/1ps
module test_tri_weight_pgen;
  localparam int unsigned NI  = 8;
  localparam int unsigned NP  = 3;
  localparam int unsigned NC  = 12;
  localparam logic [15:0] SD  = 16'hACE1;
  localparam logic [NP-1:0][NI-1:0] BFE = {8'h3F, 8'h0F, 8'h00};
  localparam logic [NP-1:0][NI-1:0] BFV = {8'h26, 8'h09, 8'h00};

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          valid, done;
  logic [NI-1:0] pat;
  logic [1:0]    phase;

  int errors = 0;
  int checks = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  tri_weight_pgen #(
    .N_IN(NI), .N_PHASE(NP), .PAT_CNT(NC), .SEED(SD),
    .FORCE_EN(BFE), .FORCE_VAL(BFV)
  ) i_tri_weight_pgen (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .valid_o(valid), .pat_o(pat), .phase_o(phase), .done_o(done)
  );

  // reference model state
  int            m_st = 0;   // 0 idle, 1 fill, 2 run, 3 done
  logic [15:0]   m_lfsr = SD;
  logic [NI-1:0] m_sr = '0;
  int            m_fill = 0, m_cnt = 0, m_ph = 0;
  int            ph_valid [NP];
  logic [NI-1:0] last_pat;
  logic          last_done = 1'b0;

  function automatic logic [NI-1:0] exp_pat(logic [NI-1:0] sr, int ph);
    logic [NI-1:0] r;
    for (int i = 0; i < NI; i++) r[i] = BFE[ph][i] ? BFV[ph][i] : sr[i];
    return r;
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_lfsr = SD; m_sr = '0; m_fill = 0; m_cnt = 0; m_ph = 0;
    end else if (start) begin
      m_st = 1; m_lfsr = SD; m_sr = '0; m_fill = 0; m_cnt = 0; m_ph = 0;
      for (int p = 0; p < NP; p++) ph_valid[p] = 0;
    end else if (m_st == 1 || m_st == 2) begin
      logic fb;
      fb = m_lfsr[15] ^ m_lfsr[13] ^ m_lfsr[12] ^ m_lfsr[10];
      m_lfsr = {m_lfsr[14:0], fb};
      m_sr   = {m_sr[NI-2:0], fb};
      if (m_st == 1) begin
        if (m_fill == NI - 1) m_st = 2; else m_fill++;
      end else if (m_cnt == NC - 1) begin
        m_cnt = 0;
        if (m_ph == NP - 1) m_st = 3; else m_ph++;
      end else begin
        m_cnt++;
      end
    end
  end

  always @(negedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected<=%0d", cyc, 100000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
    if (rst_n) begin
      chk(valid == (m_st == 2), "R3 valid", 32'(valid), 32'(m_st == 2));
      chk(done == (m_st == 3), "R9 done", 32'(done), 32'(m_st == 3));
      chk(32'(phase) == m_ph, "R6 phase", 32'(phase), 32'(m_ph));
      if (valid) begin
        ph_valid[phase]++;
        if (m_ph == 0) chk(pat == m_sr, "R4 random bits", 32'(pat), 32'(m_sr));
        else           chk(pat == exp_pat(m_sr, m_ph), "R5 forced bits", 32'(pat),
                           32'(exp_pat(m_sr, m_ph)));
        chk(pat == exp_pat(m_sr, m_ph), "R2 lfsr stream", 32'(pat), 32'(exp_pat(m_sr, m_ph)));
      end
      if (done && last_done)
        chk(pat == last_pat, "R7 pattern hold", 32'(pat), 32'(last_pat));
      last_done = done;
      last_pat  = pat;
    end
  end

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  initial begin
    int k;
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!valid && !done && phase == 0, "R1 reset", {valid, done, phase}, 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!valid && !done && phase == 0, "R1 idle", {valid, done, phase}, 0);

    // R3: fill latency, R6: per-phase counts, R7/R9: done behaviour
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    k = 1;
    while (!valid && k < 100) begin @(negedge clk); k++; end
    chk(k == NI + 1, "R3 fill latency", k, NI + 1);
    while (!done) @(negedge clk);
    for (int p = 0; p < NP; p++)
      chk(ph_valid[p] == NC, "R6 patterns per phase", ph_valid[p], NC);
    chk(32'(phase) == NP - 1, "R7 last phase at done", 32'(phase), NP - 1);
    repeat (20) @(negedge clk);
    chk(done && !valid, "R9 done held", {done, valid}, 2'b10);

    // R8: restart from done
    pulse_start();
    chk(!done && !valid && phase == 0, "R8 restart from done", {done, valid, phase}, 0);

    // R8: random restarts, including on phase boundaries
    for (int e = 0; e < 40; e++) begin
      int w;
      w = (e % 5 == 0) ? 70 : int'($urandom_range(0, NI + NP * NC + 4));
      repeat (w) @(negedge clk);
      pulse_start();
      chk(!done && !valid && phase == 0, "R8 restart mid-run", {done, valid, phase}, 0);
    end
    // directed restart right on last pattern of last phase
    while (!(valid && 32'(phase) == NP - 1 && ph_valid[NP-1] == NC - 1)) @(negedge clk);
    start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(!done && !valid && phase == 0, "R8 restart at final pattern", {done, valid, phase}, 0);
    while (!done) @(negedge clk);
    repeat (5) @(negedge clk);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule